// File: doc/BRIEF.md
# Serial Clock Baud Generator

This block produces the serial clock for a bus master that works either as a two-wire (I2C) master or as an SPI master. The clock rate comes from an 8-bit reload value held in a local register. A down-counter runs from the system clock. When it reaches zero it reloads and inverts the clock line, so one full clock period takes two expiries of the counter. A strobe from the transmit-buffer write path starts the counter. A done strobe from the transfer engine stops it. Once stopped, the clock line holds whatever level it had.

The mode input sets how often the counter steps. In I2C mode it decrements every second system clock, so each half-period lasts 2*(reload+1) cycles and the line runs at f_clk / (4*(reload+1)). For example, a 32 MHz clock with reload 0x13 gives 400 kHz, 0x4F gives 100 kHz, and a 16 MHz clock with 0x27 gives 100 kHz. In SPI mode it decrements every cycle, so each half-period lasts reload+1 cycles. Reload values below 3 are illegal in I2C mode. The block replaces them with 3 and raises an error output.

Top module: `scl_bg`

## Requirements
- R1: A synchronous active-high reset drives `scl` high, stops the counter, sets the reload register to 0x13 and leaves `rld_err` low.
- R2: A `buf_wr` pulse while stopped (and without `xfer_done` in the same cycle) starts counting. The first inversion of `scl` comes one full half-period after the clock edge that accepts the pulse.
- R3: In I2C mode (`mode_i2c` = 1), every half-period of `scl` lasts 2*(E+1) clock cycles, where E is the effective reload value.
- R4: In SPI mode (`mode_i2c` = 0), every half-period lasts E+1 clock cycles, and any reload value, including 0, is used as written.
- R5: In I2C mode a reload register value of 0, 1 or 2 is used as E = 3, and `rld_err` is high for as long as that condition holds. `rld_err` is low in SPI mode.
- R6: While `xfer_done` is high, counting stops and `scl` keeps its level. When `xfer_done` and `buf_wr` arrive in the same cycle, `xfer_done` wins.
- R7: A `buf_wr` pulse while counting has no effect on the timing of `scl`.
- R8: A reload write during a count does not change the half-period in progress. It takes effect from the next inversion of `scl`.
- R9: A restart after a stop begins a full new half-period from the level `scl` was holding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rld_we | input | 1 | Write strobe for the reload register |
| rld_data | input | 8 | New reload value |
| buf_wr | input | 1 | Transmit-buffer write, starts counting |
| xfer_done | input | 1 | Transfer complete, stops counting |
| mode_i2c | input | 1 | 1 = I2C timing, 0 = SPI timing |
| scl | output | 1 | Generated serial clock |
| rld_err | output | 1 | Reload value illegal for I2C mode (clamped) |

## Verification
The hardest case to reach is a reload write that lands in the middle of a half-period. Both the old and the new value must be observed at the right inversions. The stimulus starts a long half-period, writes a shorter value several cycles before the counter expires, and lets the reference model check the next two gaps. Clamping is reached by writing 0 and 1 in I2C mode while counting, so the model sees both the error output and the 8-cycle half-periods. Then the mode is switched to SPI with the same values, and the outputs must change to a 1-cycle half-period with no error.

// File: rtl/scl_bg_pkg.sv
package scl_bg_pkg;
    localparam int unsigned RW = 8;

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          run;
        logic          scl;
    } bg_state_t;
endpackage

// File: rtl/scl_bg_cfg.sv
module scl_bg_cfg #(
    parameter int unsigned         W       = 8,
    parameter int unsigned         MIN_I2C = 3,
    parameter logic [W-1:0]        RST_VAL = 8'h13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         i2c,
    output logic [W-1:0] eff,
    output logic         bad
);
    localparam logic [W-1:0] FLOOR = W'(MIN_I2C);

    logic [W-1:0] rld_d, rld_q;

    always_comb begin
        rld_d = we ? wdata : rld_q;
        bad   = i2c && (rld_q < FLOOR);
        eff   = bad ? FLOOR : rld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rld_q <= RST_VAL;
        else     rld_q <= rld_d;
    end
endmodule

// File: rtl/scl_bg_tick.sv
module scl_bg_tick (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic i2c,
    output logic tick
);
    logic pre_d, pre_q;

    always_comb begin
        pre_d = (run && i2c) ? ~pre_q : 1'b0;
        tick  = i2c ? pre_q : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pre_q <= 1'b0;
        else     pre_q <= pre_d;
    end
endmodule

// File: rtl/scl_bg.sv
module scl_bg
    import scl_bg_pkg::*;
#(
    parameter int unsigned W       = RW,
    parameter int unsigned MIN_I2C = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rld_we,
    input  logic [W-1:0] rld_data,
    input  logic         buf_wr,
    input  logic         xfer_done,
    input  logic         mode_i2c,
    output logic         scl,
    output logic         rld_err
);
    bg_state_t    state_d, state_q;
    logic [W-1:0] eff;
    logic         tick;
    logic         run_w;
    logic [W-1:0] cnt_w;

    scl_bg_cfg #(.W(W), .MIN_I2C(MIN_I2C), .RST_VAL(W'(8'h13))) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (rld_we),
        .wdata (rld_data),
        .i2c   (mode_i2c),
        .eff   (eff),
        .bad   (rld_err)
    );

    scl_bg_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q.run),
        .i2c  (mode_i2c),
        .tick (tick)
    );

    always_comb begin
        state_d = state_q;
        if (!state_q.run) begin
            if (buf_wr && !xfer_done) begin
                state_d.run = 1'b1;
                state_d.cnt = RW'(eff);
            end
        end else if (xfer_done) begin
            state_d.run = 1'b0;
        end else if (tick) begin
            if (state_q.cnt == '0) begin
                state_d.scl = ~state_q.scl;
                state_d.cnt = RW'(eff);
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.cnt <= '0;
            state_q.run <= 1'b0;
            state_q.scl <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign scl   = state_q.scl;
    assign run_w = state_q.run;
    assign cnt_w = W'(state_q.cnt);
endmodule

// File: rtl/scl_bg_chk.sv
module scl_bg_chk #(
    parameter int unsigned W       = 8,
    parameter int unsigned MIN_I2C = 3
) (
    input logic         clk,
    input logic         rst,
    input logic         buf_wr,
    input logic         xfer_done,
    input logic         mode_i2c,
    input logic         scl,
    input logic         rld_err,
    input logic         run,
    input logic [W-1:0] cnt
);
    assert_reset_high_R1: assert property (@(posedge clk) rst |=> (scl && !run));

    assert_start_R2: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && !run && !xfer_done) |=> run);

    assert_clamped_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_i2c && $past(mode_i2c) && (scl != $past(scl))) |-> (cnt >= W'(MIN_I2C)));

    assert_err_only_i2c_R5: assert property (@(posedge clk) disable iff (rst)
        rld_err |-> mode_i2c);

    assert_stop_R6: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> !run);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(scl));
endmodule

bind scl_bg scl_bg_chk #(.W(W), .MIN_I2C(MIN_I2C)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .buf_wr    (buf_wr),
    .xfer_done (xfer_done),
    .mode_i2c  (mode_i2c),
    .scl       (scl),
    .rld_err   (rld_err),
    .run       (run_w),
    .cnt       (cnt_w)
);

// File: tb/test_scl_bg.sv
module test_scl_bg;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rld_we = 1'b0;
    logic [7:0] rld_data = '0;
    logic       buf_wr = 1'b0;
    logic       xfer_done = 1'b0;
    logic       mode_i2c = 1'b1;
    logic       scl;
    logic       rld_err;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";

    bit       m_run;
    bit       m_scl;
    int       m_rem;
    bit [7:0] m_rld;
    bit       done_flag = 1'b0;

    always #5 clk = ~clk;

    scl_bg i_scl_bg (
        .clk(clk), .rst(rst), .rld_we(rld_we), .rld_data(rld_data),
        .buf_wr(buf_wr), .xfer_done(xfer_done), .mode_i2c(mode_i2c),
        .scl(scl), .rld_err(rld_err)
    );

    function automatic int half_len(bit [7:0] r, bit i2c);
        int e;
        e = (i2c && r < 3) ? 3 : int'(r);
        return i2c ? 2 * (e + 1) : (e + 1);
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model, updated on each rising edge and compared 2 ns later.
    always @(posedge clk) begin
        bit [7:0] old;
        if (rst) begin
            m_run = 1'b0; m_scl = 1'b1; m_rld = 8'h13; m_rem = 0;
        end else begin
            old = m_rld;
            if (m_run) begin
                if (xfer_done) m_run = 1'b0;
                else begin
                    m_rem--;
                    if (m_rem == 0) begin
                        m_scl = !m_scl;
                        m_rem = half_len(old, mode_i2c);
                    end
                end
            end else if (buf_wr && !xfer_done) begin
                m_run = 1'b1;
                m_rem = half_len(old, mode_i2c);
            end
            if (rld_we) m_rld = rld_data;
        end
        #2;
        if (!rst && !done_flag) begin
            check(cur_req, scl, m_scl, "scl");
            check(cur_req, rld_err, mode_i2c && (m_rld < 3), "rld_err");
        end
    end

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_wr();
        @(negedge clk); buf_wr = 1'b1;
        @(negedge clk); buf_wr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic write_rld(bit [7:0] v);
        @(negedge clk); rld_we = 1'b1; rld_data = v;
        @(negedge clk); rld_we = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        @(negedge clk); rst = 1'b0;
        cur_req = "R1";
        check("R1", scl, 1'b1, "scl after reset");
        check("R1", rld_err, 1'b0, "rld_err after reset");
        cyc(5);

        cur_req = "R2";
        write_rld(8'h05);
        pulse_wr();
        cur_req = "R3";
        cyc(60);
        cur_req = "R7";
        pulse_wr();
        cyc(7);
        pulse_wr();
        cyc(30);
        cur_req = "R8";
        write_rld(8'h0A);
        cyc(9);
        write_rld(8'h03);
        cyc(80);

        cur_req = "R6";
        pulse_done();
        cyc(25);
        @(negedge clk); buf_wr = 1'b1; xfer_done = 1'b1;
        @(negedge clk); buf_wr = 1'b0; xfer_done = 1'b0;
        cyc(15);

        cur_req = "R9";
        pulse_wr();
        cyc(23);
        pulse_done();
        cyc(6);
        pulse_wr();
        cyc(40);

        cur_req = "R5";
        write_rld(8'h01);
        cyc(40);
        write_rld(8'h00);
        cyc(40);
        write_rld(8'h02);
        cyc(30);
        pulse_done();
        cyc(3);

        cur_req = "R4";
        @(negedge clk); mode_i2c = 1'b0;
        cyc(3);
        pulse_wr();
        cyc(20);
        write_rld(8'h00);
        cyc(12);
        write_rld(8'h04);
        cyc(30);
        pulse_done();
        cyc(4);
        cur_req = "R5";
        write_rld(8'h01);
        cyc(3);
        check("R5", rld_err, 1'b0, "rld_err in SPI mode");
        @(negedge clk); mode_i2c = 1'b1;
        cyc(1);
        check("R5", rld_err, 1'b1, "rld_err in I2C mode with reload 1");
        cur_req = "R3";
        write_rld(8'h4F);
        pulse_wr();
        cyc(700);
        pulse_done();
        cyc(5);
        finish_run();
    end
endmodule